// File: doc/BRIEF.md
# Dual-Instruction Fetch Skid Buffer

This block sits between the second fetch stage of a pipelined instruction memory and the decode stage of a dual-issue in-order core. Each fetch returns one packet of two 32-bit instructions, and the fetch address moves forward by 8 bytes per packet. The memory answers one cycle after it is asked, so when decode stalls, a packet that was requested in the previous cycle is still on its way. The block keeps that packet and every other returning packet in a two-entry store, so nothing is lost. It also drives the fetch enable that the program-counter logic uses to decide whether to issue a request.

When the store is empty and decode is not stalled, an arriving packet goes straight through to decode in the same cycle and is not written. In every other case a valid arriving packet is written at the write pointer, and decode reads from the read pointer. The two pointers have their own push and pop logic. A flush for a redirect empties the store in one cycle.

The controller is a three-state machine. ST_EMPTY holds no packet, ST_PART holds some but not all entries, and ST_FULL holds every entry. It takes these transitions:
- T_CAPTURE (ST_EMPTY to ST_PART): a packet arrives while decode stalls.
- T_FILL (ST_PART to ST_FULL): a packet is stored and none is popped.
- T_DRAIN (ST_FULL to ST_PART, or ST_PART to ST_EMPTY): a pop with no store.
- T_FLUSH (any state to ST_EMPTY): a flush.

In every other case the state holds. This includes a store and a pop in the same cycle.

Top module: `fetch_skid_buffer`

## Requirements
- R1: After reset, out_valid is 0 and fetch_en is 1, and the store is empty.
- R2: When the store is empty, decode is not stalled, flush is low and in_valid is 1, out_valid is 1 and out_pkt equals in_pkt in the same cycle. The packet is not stored, so in the next cycle with in_valid low, out_valid is 0.
- R3: Packets that arrive while decode stalls, or while the store is not empty, are stored. They reach decode in arrival order once the stall ends, one per unstalled cycle. With the store not empty, a push and a pop in the same cycle leave the occupancy unchanged.
- R4: fetch_en is 0 exactly when the current occupancy, plus the packet stored this cycle, minus the packet popped this cycle, reaches DEPTH (2). A packet returning in the next cycle therefore always finds a free entry. fetch_en is 1 whenever the store is empty.
- R5: When the store is empty and in_valid is 0, out_valid is 0.
- R6: While flush is 1, out_valid is 0, fetch_en is 1 and nothing is written. In the next cycle the store is empty.
- R7: A packet with in_valid 0 is never written, whatever the value on in_pkt.
- R8: The packet layout is kept as it is. Bits [31:0] carry the first instruction (lane 0), at the lower address. Bits [63:32] carry the second instruction (lane 1), at address +4.
- R9: While decode stalls and flush is low, a packet on the output stays there. In the next cycle out_valid is still 1 and out_pkt is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Redirect: discard all stored packets |
| dec_stall | input | 1 | Decode cannot accept a packet this cycle |
| in_valid | input | 1 | A packet arrives from the second fetch stage |
| in_pkt | input | 64 | Arriving packet, lane 0 in bits [31:0] |
| out_valid | output | 1 | A packet is presented to decode |
| out_pkt | output | 64 | Presented packet, lane 0 in bits [31:0] |
| fetch_en | output | 1 | The program-counter logic may issue a fetch this cycle |

## Verification
The hardest case to reach is the store at ST_FULL with fetch_en low. Getting there takes two packets arriving in consecutive stalled cycles, where the second was requested in the very cycle that the first was being captured from the bypass path. The stimulus table obeys the fetch contract: it raises in_valid only one cycle after fetch_en was sampled high. It stalls across two returning packets, then holds the stall for one idle cycle so the throttled state is seen on its own, and then releases the stall. Flushes are applied both with a valid packet on the input over an empty store and over a full store. An invalid cycle carrying a poisoned packet is placed between a capture and a drain.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    localparam int unsigned INSN_W_DEF = 32;
    localparam int unsigned LANES_DEF  = 2;
    localparam int unsigned DEPTH_DEF  = 2;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/fsb_store.sv
module fsb_store #(
    parameter int unsigned PKT_W = 64,
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [PKT_W-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [PKT_W-1:0] rd_data
);

    logic [PTR_W-1:0] wr_ptr_q;
    logic [PKT_W-1:0] entry_q [DEPTH];

    // write pointer: advances once per stored packet, wraps at DEPTH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
        end else if (push) begin
            if (wr_ptr_q == PTR_W'(DEPTH - 1)) begin
                wr_ptr_q <= '0;
            end else begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
        end
    end

    // one register per entry, written only when selected
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic sel;
        assign sel = push && (wr_ptr_q == PTR_W'(e));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[e] <= '0;
            end else if (sel) begin
                entry_q[e] <= wr_data;
            end
        end
    end

    assign rd_data = entry_q[rd_ptr];

endmodule

// File: rtl/fsb_pop.sv
module fsb_pop #(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pop,
    output logic [PTR_W-1:0] rd_ptr
);

    logic [PTR_W-1:0] rd_ptr_q;

    // read pointer: advances once per packet taken by decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
        end else if (flush) begin
            rd_ptr_q <= '0;
        end else if (pop) begin
            if (rd_ptr_q == PTR_W'(DEPTH - 1)) begin
                rd_ptr_q <= '0;
            end else begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
        end
    end

    assign rd_ptr = rd_ptr_q;

endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
    import fsb_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic dec_stall,
    input  logic in_valid,
    output logic push,
    output logic pop,
    output logic empty,
    output logic fetch_en
);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   proj;
    logic             is_empty, is_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // decode of the current state
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        unique case (state_q)
            ST_EMPTY: is_empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  is_full = 1'b1;
            default:  is_empty = 1'b1;
        endcase
    end

    // outputs: push/pop strobes and the fetch throttle
    always_comb begin
        push = in_valid && !flush && !(is_empty && !dec_stall);
        pop  = !is_empty && !dec_stall && !flush;
        proj = {1'b0, cnt_q} + (CNT_W + 1)'(push) - (CNT_W + 1)'(pop);
        fetch_en = flush || (proj < (CNT_W + 1)'(DEPTH));
        empty = is_empty;
    end

    // next occupancy and transitions T_CAPTURE/T_FILL/T_DRAIN/T_FLUSH
    always_comb begin
        cnt_d   = cnt_q;
        state_d = state_q;
        if (flush) begin
            cnt_d   = '0;
            state_d = ST_EMPTY;
        end else begin
            cnt_d = proj[CNT_W-1:0];
            unique case (state_q)
                ST_EMPTY: begin
                    if (push) state_d = (DEPTH == 1) ? ST_FULL : ST_PART;
                end
                ST_PART: begin
                    if (cnt_d == '0) begin
                        state_d = ST_EMPTY;
                    end else if (cnt_d == CNT_W'(DEPTH)) begin
                        state_d = ST_FULL;
                    end
                end
                ST_FULL: begin
                    if (cnt_d == '0) begin
                        state_d = ST_EMPTY;
                    end else if (cnt_d != CNT_W'(DEPTH)) begin
                        state_d = ST_PART;
                    end
                end
                default: begin
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end
            endcase
        end
        if (is_full && push && !pop) begin
            cnt_d = cnt_q;
        end
    end

endmodule

// File: rtl/fetch_skid_buffer.sv
module fetch_skid_buffer
    import fsb_pkg::*;
#(
    parameter int unsigned INSN_W = INSN_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF,
    localparam int unsigned PKT_W = INSN_W * LANES,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             dec_stall,
    input  logic             in_valid,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             out_valid,
    output logic [PKT_W-1:0] out_pkt,
    output logic             fetch_en
);

    logic             push, pop, buf_empty;
    logic [PTR_W-1:0] rd_ptr;
    logic [PKT_W-1:0] head_pkt;

    fsb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .dec_stall (dec_stall),
        .in_valid  (in_valid),
        .push      (push),
        .pop       (pop),
        .empty     (buf_empty),
        .fetch_en  (fetch_en)
    );

    fsb_store #(.PKT_W(PKT_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (push),
        .wr_data (in_pkt),
        .rd_ptr  (rd_ptr),
        .rd_data (head_pkt)
    );

    fsb_pop #(.DEPTH(DEPTH)) pop_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .pop    (pop),
        .rd_ptr (rd_ptr)
    );

    // bypass when empty; lanes pass through in place
    always_comb begin
        out_valid = !flush && (!buf_empty || in_valid);
        out_pkt   = buf_empty ? in_pkt : head_pkt;
    end

endmodule

// File: rtl/fsb_chk.sv
module fsb_chk #(
    parameter int unsigned PKT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             dec_stall,
    input logic             in_valid,
    input logic [PKT_W-1:0] in_pkt,
    input logic             out_valid,
    input logic [PKT_W-1:0] out_pkt,
    input logic             fetch_en,
    input logic             buf_empty
);

    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty && in_valid && !dec_stall && !flush |-> out_valid && (out_pkt == in_pkt));

    p_throttle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> fetch_en);

    p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty && !in_valid |-> !out_valid);

    p_flush_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !out_valid && fetch_en);

    p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> buf_empty);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && dec_stall && !flush |=> flush || (out_valid && (out_pkt == $past(out_pkt))));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> !buf_empty);

endmodule

bind fetch_skid_buffer fsb_chk #(.PKT_W(PKT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .dec_stall (dec_stall),
    .in_valid  (in_valid),
    .in_pkt    (in_pkt),
    .out_valid (out_valid),
    .out_pkt   (out_pkt),
    .fetch_en  (fetch_en),
    .buf_empty (buf_empty)
);

// File: tb/fetch_skid_buffer_tb_top.sv
module fetch_skid_buffer_tb_top;

    localparam int unsigned PKT_W = 64;
    localparam int NV = 21;

    typedef struct packed {
        logic       fl;
        logic       st;
        logic       iv;
        logic [7:0] itag;
        logic       ev;
        logic [7:0] etag;
        logic       fen;
        logic [3:0] req;
    } vec_t;

    // fl st iv itag  ev etag  fen req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd1}, // idle after reset
        '{1'b0, 1'b0, 1'b1, 8'h01, 1'b1, 8'h01, 1'b1, 4'd2}, // bypass
        '{1'b0, 1'b0, 1'b1, 8'h02, 1'b1, 8'h02, 1'b1, 4'd8}, // lanes in place
        '{1'b0, 1'b1, 1'b1, 8'h03, 1'b1, 8'h03, 1'b1, 4'd3}, // capture
        '{1'b0, 1'b1, 1'b1, 8'h04, 1'b1, 8'h03, 1'b0, 4'd4}, // fill, throttle
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h03, 1'b0, 4'd4}, // full, still stalled
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h03, 1'b1, 4'd3}, // drain oldest
        '{1'b0, 1'b0, 1'b1, 8'h05, 1'b1, 8'h04, 1'b1, 4'd3}, // push+pop
        '{1'b0, 1'b0, 1'b1, 8'h06, 1'b1, 8'h05, 1'b1, 4'd3}, // push+pop
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h06, 1'b1, 4'd3}, // last one
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd2}, // empty again
        '{1'b1, 1'b0, 1'b1, 8'h07, 1'b0, 8'h00, 1'b1, 4'd6}, // flush drops input
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd6}, // nothing kept
        '{1'b0, 1'b1, 1'b1, 8'h08, 1'b1, 8'h08, 1'b1, 4'd9}, // stalled bypass
        '{1'b0, 1'b1, 1'b1, 8'h09, 1'b1, 8'h08, 1'b0, 4'd4}, // held, full
        '{1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd6}, // flush full store
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd6}, // emptied
        '{1'b0, 1'b1, 1'b1, 8'h0A, 1'b1, 8'h0A, 1'b1, 4'd9}, // capture
        '{1'b0, 1'b1, 1'b0, 8'hEE, 1'b1, 8'h0A, 1'b1, 4'd7}, // invalid poison
        '{1'b0, 1'b0, 1'b0, 8'hEE, 1'b1, 8'h0A, 1'b1, 4'd7}, // pop only 0A
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd5}  // empty, quiet
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             dec_stall = 1'b0;
    logic             in_valid = 1'b0;
    logic [PKT_W-1:0] in_pkt = '0;
    logic             out_valid;
    logic [PKT_W-1:0] out_pkt;
    logic             fetch_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fetch_skid_buffer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .dec_stall (dec_stall),
        .in_valid  (in_valid),
        .in_pkt    (in_pkt),
        .out_valid (out_valid),
        .out_pkt   (out_pkt),
        .fetch_en  (fetch_en)
    );

    // lane 1 in the upper half, lane 0 (first instruction) in the lower
    function automatic logic [PKT_W-1:0] mk(input logic [7:0] t);
        return {24'hAAAA00, t, 24'h555500, t};
    endfunction

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string rq, input logic [PKT_W+1:0] act, input logic [PKT_W+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1", {out_valid, fetch_en, {PKT_W{1'b0}}}, {1'b0, 1'b1, {PKT_W{1'b0}}});
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            flush     = VECS[i].fl;
            dec_stall = VECS[i].st;
            in_valid  = VECS[i].iv;
            in_pkt    = mk(VECS[i].itag);
            #2;
            check(req_name(VECS[i].req),
                  {out_valid, fetch_en, out_valid ? out_pkt : {PKT_W{1'b0}}},
                  {VECS[i].ev, VECS[i].fen, VECS[i].ev ? mk(VECS[i].etag) : {PKT_W{1'b0}}});
        end

        // R8: distinct instructions per lane keep their positions
        @(negedge clk);
        dec_stall = 1'b0;
        flush = 1'b0;
        in_valid = 1'b1;
        in_pkt = {32'h0000_2013, 32'h0000_1093};
        #2;
        check("R8", {out_valid, fetch_en, out_pkt}, {1'b1, 1'b1, 32'h0000_2013, 32'h0000_1093});

        // R1: asynchronous reset from a full store
        @(negedge clk);
        dec_stall = 1'b1;
        in_pkt = mk(8'h11);
        @(negedge clk);
        in_pkt = mk(8'h12);
        #2;
        check("R4", {out_valid, fetch_en, out_pkt}, {1'b1, 1'b0, mk(8'h11)});
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", {out_valid, fetch_en, {PKT_W{1'b0}}}, {1'b0, 1'b1, {PKT_W{1'b0}}});
        @(negedge clk);
        rst_n = 1'b1;
        dec_stall = 1'b0;
        @(negedge clk);
        #2;
        check("R5", {out_valid, fetch_en, {PKT_W{1'b0}}}, {1'b0, 1'b1, {PKT_W{1'b0}}});

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule